// File: doc/BRIEF.md
# Multi-channel DMA beat scheduler

This block decides which of several DMA channels may use a shared data-move engine and hands that engine one beat at a time. Each channel is loaded through a small write port with a transfer count, a transfer mode and a burst-size code. It then waits for its request input. A channel in single mode gets exactly one beat per request. A channel in burst mode needs one request, and then runs burst after burst until its count is used up.

When the engine is free, the scheduler grants the highest-numbered channel that is ready to go. It then issues that channel's run of beats over a valid/ready handshake. No other channel can take the engine until the run's last beat is accepted. At the end of a run, the channel's remaining count drops by the run length. When the count reaches zero, a one-cycle done pulse is raised for that channel.

The result is that a single-mode channel with higher priority slips its beats in between the bursts of a lower-priority burst channel. The burst channel then picks up again with its next burst. Burst mode is meant for memory-to-memory moves. Channels tied to a peripheral are programmed in single mode.

Top module: `dma_beat_sched`

## Requirements
- R1: While `rst` is high, and right after it is released, every channel count reads zero, `beat_valid_o` is low and `done_o` is all zero.
- R2: A write with `cfg_we_i` high loads the channel selected by `cfg_ch_i`. It sets the mode (`cfg_burst_i` 1 = burst, 0 = single), the size code and the count, and clears any pending request. The new count shows on `count_o` the next cycle. A write to the channel that owns the engine, or that is granted in the same cycle, is ignored.
- R3: In single mode, each run is exactly one beat and reduces the count by one. The size code has no effect.
- R4: A single-mode request that arrives while the engine is busy is held as pending until served. Several requests that arrive before the channel is served count as one beat.
- R5: In burst mode, a run is 2^k beats for size code k (0..7, so 1 to 128 beats), or the remaining count if that is smaller. The count drops by the run length when the run's last beat is accepted.
- R6: A burst-mode channel needs one request for its whole count. It goes on to its next burst without any new request.
- R7: Arbitration happens only while the engine is idle, one cycle after the previous run ends. It grants the highest-indexed channel that has a nonzero count and is either pending (single mode) or started (burst mode).
- R8: A run is never preempted. `beat_ch_o` holds steady from the first beat to the last. `beat_valid_o` stays high until `beat_ready_i` accepts each beat. `beat_last_o` marks the final beat of the run.
- R9: `done_o[i]` pulses for exactly one cycle, in the cycle after channel i's count reaches zero.
- R10: A channel whose count is zero ignores its request input. It issues no beat until it is reprogrammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Channel configuration write strobe |
| cfg_ch_i | input | IDX_W | Channel to configure |
| cfg_burst_i | input | 1 | 1 = burst mode, 0 = single mode |
| cfg_size_i | input | BSZ_W | Burst-size code k, run length 2^k |
| cfg_count_i | input | CNT_W | Transfer count to load |
| req_i | input | NCH | Per-channel request inputs |
| beat_valid_o | output | 1 | A beat is offered to the data mover |
| beat_ready_i | input | 1 | Data mover accepts the offered beat |
| beat_ch_o | output | IDX_W | Channel that owns the offered beat |
| beat_last_o | output | 1 | Offered beat is the last of its run |
| done_o | output | NCH | One-cycle per-channel completion pulse |
| count_o | output | NCH*CNT_W | Remaining count, channel i at bits [i*CNT_W +: CNT_W] |

## Verification
The bench builds the block with two channels, a 14-bit count and a 3-bit size code. This keeps the largest 128-beat burst within reach, along with a 256-beat burst transfer that runs against a 128-beat single-mode channel with higher priority. With two channels, every interleaving of single beats between bursts can be traced beat by beat against a behavioural model. Further cases in the same setup cover:
- a short final burst (runs of 4, 4, 2);
- requests that collapse while the engine is busy;
- a write that is dropped because it targets the running channel;
- requests to a channel whose count is zero;
- a data mover that stalls the handshake on a repeating pattern.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_BURST  = 1'b1
    } xfer_mode_e;

    // Beats granted to a channel for one run.
    function automatic int unsigned run_length(input xfer_mode_e  mode,
                                               input int unsigned code,
                                               input int unsigned remain);
        int unsigned full;
        full = 32'd1 << code;
        if (mode == MODE_SINGLE) return 32'd1;
        return (remain < full) ? remain : full;
    endfunction

endpackage

// File: rtl/dma_chan_slot.sv
module dma_chan_slot import dma_sched_pkg::*; #(
    parameter int CNT_W = 14,
    parameter int BSZ_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  xfer_mode_e       wr_mode_i,
    input  logic [BSZ_W-1:0] wr_size_i,
    input  logic [CNT_W-1:0] wr_count_i,
    input  logic             req_i,
    input  logic             grant_i,
    input  logic             retire_i,
    input  logic [CNT_W-1:0] retire_len_i,
    output logic             eligible_o,
    output xfer_mode_e       mode_o,
    output logic [BSZ_W-1:0] size_o,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [BSZ_W-1:0] size_q;
    xfer_mode_e       mode_q;
    logic             pend_q, armed_q, done_q;
    logic             has_work;

    assign has_work = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            size_q  <= '0;
            mode_q  <= MODE_SINGLE;
            pend_q  <= 1'b0;
            armed_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (wr_i) begin
                cnt_q   <= wr_count_i;
                size_q  <= wr_size_i;
                mode_q  <= wr_mode_i;
                pend_q  <= 1'b0;
                armed_q <= 1'b0;
            end else begin
                pend_q <= (pend_q & ~grant_i) |
                          (req_i & has_work & (mode_q == MODE_SINGLE));
                if (req_i && has_work && mode_q == MODE_BURST)
                    armed_q <= 1'b1;
                if (retire_i) begin
                    cnt_q <= cnt_q - retire_len_i;
                    if (cnt_q == retire_len_i) begin
                        armed_q <= 1'b0;
                        done_q  <= 1'b1;
                    end
                end
            end
        end
    end

    assign eligible_o = has_work & ((mode_q == MODE_BURST) ? armed_q : pend_q);
    assign mode_o     = mode_q;
    assign size_o     = size_q;
    assign count_o    = cnt_q;
    assign done_o     = done_q;

    // R5
    cnt_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> cnt_q <= $past(cnt_q));

    // R9
    done_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> cnt_q == '0);

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NCH   = 4,
    parameter int IDX_W = 2
) (
    input  logic [NCH-1:0]   elig_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < NCH; i++) begin
            if (elig_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma_run_seq.sv
module dma_run_seq #(
    parameter int IDX_W = 2,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [IDX_W-1:0] start_ch_i,
    input  logic [LEN_W-1:0] start_len_i,
    input  logic             ready_i,
    output logic             busy_o,
    output logic [IDX_W-1:0] ch_o,
    output logic             last_o,
    output logic             retire_o,
    output logic [LEN_W-1:0] len_o
);
    logic             busy_q;
    logic [IDX_W-1:0] ch_q;
    logic [LEN_W-1:0] left_q, len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ch_q   <= '0;
            left_q <= '0;
            len_q  <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                ch_q   <= start_ch_i;
                left_q <= start_len_i;
                len_q  <= start_len_i;
            end
        end else if (ready_i) begin
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) busy_q <= 1'b0;
        end
    end

    assign busy_o   = busy_q;
    assign ch_o     = ch_q;
    assign last_o   = busy_q && (left_q == LEN_W'(1));
    assign retire_o = last_o && ready_i;
    assign len_o    = len_q;

    // R8
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && !ready_i |=> busy_q && $stable(ch_q) && $stable(left_q));

    // R8
    run_owner_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && !last_o |=> busy_q && $stable(ch_q));

endmodule

// File: rtl/dma_beat_sched.sv
module dma_beat_sched import dma_sched_pkg::*; #(
    parameter int NCH   = 4,
    parameter int CNT_W = 14,
    parameter int BSZ_W = 3,
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we_i,
    input  logic [IDX_W-1:0]     cfg_ch_i,
    input  logic                 cfg_burst_i,
    input  logic [BSZ_W-1:0]     cfg_size_i,
    input  logic [CNT_W-1:0]     cfg_count_i,
    input  logic [NCH-1:0]       req_i,
    output logic                 beat_valid_o,
    input  logic                 beat_ready_i,
    output logic [IDX_W-1:0]     beat_ch_o,
    output logic                 beat_last_o,
    output logic [NCH-1:0]       done_o,
    output logic [NCH*CNT_W-1:0] count_o
);
    localparam int LEN_W = 2 ** BSZ_W;

    logic [NCH-1:0]   elig;
    logic [CNT_W-1:0] cnt_a  [NCH];
    logic [BSZ_W-1:0] size_a [NCH];
    xfer_mode_e       mode_a [NCH];
    logic             any_elig, busy, retire, grant;
    logic [IDX_W-1:0] pick, cur;
    logic [LEN_W-1:0] start_len, run_len;

    assign grant     = !busy && any_elig;
    assign start_len = LEN_W'(run_length(mode_a[pick], 32'(size_a[pick]),
                                         32'(cnt_a[pick])));

    dma_prio_pick #(.NCH(NCH), .IDX_W(IDX_W)) i_pick (
        .elig_i (elig),
        .any_o  (any_elig),
        .idx_o  (pick)
    );

    dma_run_seq #(.IDX_W(IDX_W), .LEN_W(LEN_W)) i_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (grant),
        .start_ch_i  (pick),
        .start_len_i (start_len),
        .ready_i     (beat_ready_i),
        .busy_o      (busy),
        .ch_o        (cur),
        .last_o      (beat_last_o),
        .retire_o    (retire),
        .len_o       (run_len)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        logic owned, wr, grant_g, retire_g;
        assign owned    = (busy && cur == IDX_W'(g)) || (grant && pick == IDX_W'(g));
        assign wr       = cfg_we_i && (cfg_ch_i == IDX_W'(g)) && !owned;
        assign grant_g  = grant && (pick == IDX_W'(g));
        assign retire_g = retire && (cur == IDX_W'(g));

        dma_chan_slot #(.CNT_W(CNT_W), .BSZ_W(BSZ_W)) i_slot (
            .clk          (clk),
            .rst          (rst),
            .wr_i         (wr),
            .wr_mode_i    (xfer_mode_e'(cfg_burst_i)),
            .wr_size_i    (cfg_size_i),
            .wr_count_i   (cfg_count_i),
            .req_i        (req_i[g]),
            .grant_i      (grant_g),
            .retire_i     (retire_g),
            .retire_len_i (CNT_W'(run_len)),
            .eligible_o   (elig[g]),
            .mode_o       (mode_a[g]),
            .size_o       (size_a[g]),
            .count_o      (cnt_a[g]),
            .done_o       (done_o[g])
        );
        assign count_o[g*CNT_W +: CNT_W] = cnt_a[g];
    end

    assign beat_valid_o = busy;
    assign beat_ch_o    = cur;

    // R3
    single_one_beat_chk: assert property (@(posedge clk) disable iff (rst)
        beat_valid_o && mode_a[beat_ch_o] == MODE_SINGLE |-> beat_last_o);

    // R9
    done_sparse_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done_o));

    // R9
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o != '0 |=> (done_o & $past(done_o)) == '0);

endmodule

// File: tb/test_dma_beat_sched.sv
module test_dma_beat_sched;
    localparam int CLK_PERIOD = 10;
    localparam int NCH   = 2;
    localparam int CNT_W = 14;
    localparam int BSZ_W = 3;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 cfg_we = 1'b0;
    logic [0:0]           cfg_ch = '0;
    logic                 cfg_burst = 1'b0;
    logic [BSZ_W-1:0]     cfg_size = '0;
    logic [CNT_W-1:0]     cfg_count = '0;
    logic [NCH-1:0]       req = '0;
    logic                 beat_valid, beat_ready = 1'b1, beat_last;
    logic [0:0]           beat_ch;
    logic [NCH-1:0]       done;
    logic [NCH*CNT_W-1:0] count;

    dma_beat_sched #(.NCH(NCH), .CNT_W(CNT_W), .BSZ_W(BSZ_W)) i_dma_beat_sched (
        .clk(clk), .rst(rst), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
        .cfg_burst_i(cfg_burst), .cfg_size_i(cfg_size), .cfg_count_i(cfg_count),
        .req_i(req), .beat_valid_o(beat_valid), .beat_ready_i(beat_ready),
        .beat_ch_o(beat_ch), .beat_last_o(beat_last), .done_o(done), .count_o(count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0, cyc = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int m_cnt[NCH], m_size[NCH];
    bit m_burst[NCH], m_pend[NCH], m_armed[NCH], m_done[NCH];
    bit m_busy;
    int m_cur, m_left, m_len;

    // Port-level monitor.
    int beats[NCH], done_cnt[NCH], first_ch = -1, run_acc = 0;
    int ch0_runs[$];

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                m_cnt[i] = 0; m_size[i] = 0; m_burst[i] = 0;
                m_pend[i] = 0; m_armed[i] = 0; m_done[i] = 0;
            end
            m_busy = 0; m_cur = 0; m_left = 0; m_len = 0;
        end else begin
            int pick, len, own;
            bit fire;
            if (beat_valid && beat_ready) begin
                beats[beat_ch]++;
                if (first_ch < 0) first_ch = int'(beat_ch);
                if (beat_ch == 1'b0) begin
                    run_acc++;
                    if (beat_last) begin ch0_runs.push_back(run_acc); run_acc = 0; end
                end
            end
            for (int i = 0; i < NCH; i++) if (done[i]) done_cnt[i]++;

            pick = -1;
            if (!m_busy)
                for (int i = 0; i < NCH; i++)
                    if (m_cnt[i] != 0 && (m_burst[i] ? m_armed[i] : m_pend[i])) pick = i;
            len = 1;
            if (pick >= 0 && m_burst[pick])
                len = ((1 << m_size[pick]) < m_cnt[pick]) ? (1 << m_size[pick]) : m_cnt[pick];
            fire = m_busy && beat_ready;
            own  = m_busy ? m_cur : pick;
            for (int i = 0; i < NCH; i++) begin
                m_done[i] = 0;
                if (m_cnt[i] != 0 && req[i]) begin
                    if (m_burst[i]) m_armed[i] = 1;
                    else            m_pend[i] = 1;
                end else if (pick == i) m_pend[i] = 0;
            end
            if (fire) begin
                if (m_left == 1) begin
                    m_busy = 0;
                    m_cnt[m_cur] -= m_len;
                    if (m_cnt[m_cur] == 0) begin
                        m_armed[m_cur] = 0;
                        m_done[m_cur]  = 1;
                    end
                end else m_left--;
            end
            if (pick >= 0) begin
                m_busy = 1; m_cur = pick; m_left = len; m_len = len;
            end
            if (cfg_we && int'(cfg_ch) != own) begin
                m_cnt[cfg_ch] = int'(cfg_count); m_size[cfg_ch] = int'(cfg_size);
                m_burst[cfg_ch] = cfg_burst; m_pend[cfg_ch] = 0; m_armed[cfg_ch] = 0;
            end
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (!rst) begin
            check(beat_valid == m_busy, "R8 beat_valid", beat_valid, m_busy);
            if (m_busy) begin
                check(int'(beat_ch) == m_cur, "R7 beat_ch", beat_ch, m_cur);
                check(beat_last == (m_left == 1), "R8 beat_last", beat_last, m_left == 1);
            end
            for (int i = 0; i < NCH; i++) begin
                check(done[i] == m_done[i], "R9 done", done[i], m_done[i]);
                check(int'(count[i*CNT_W +: CNT_W]) == m_cnt[i], "R5 count",
                      count[i*CNT_W +: CNT_W], m_cnt[i]);
            end
        end
    end

    initial forever begin
        @(negedge clk);
        beat_ready = (cyc % 7 != 3);
    end

    task automatic cfg_write(input int ch, input bit burst, input int size, input int cnt);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch[0:0]; cfg_burst = burst;
        cfg_size = size[BSZ_W-1:0]; cfg_count = cnt[CNT_W-1:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_req(input logic [NCH-1:0] v);
        @(negedge clk);
        req = v;
        @(negedge clk);
        req = '0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            quiet = beat_valid ? 0 : quiet + 1;
        end
    endtask

    function automatic int cnt_of(input int ch);
        return int'(count[ch*CNT_W +: CNT_W]);
    endfunction

    initial begin
        int guard;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(beat_valid == 1'b0, "R1 valid in reset", beat_valid, 0);
        check(done == '0, "R1 done in reset", done, 0);
        rst = 1'b0;
        @(negedge clk);
        check(count == '0, "R1 counts after reset", count, 0);

        // R10: zero-count channels ignore requests
        pulse_req(2'b11);
        repeat (4) @(negedge clk);
        check(beats[0] + beats[1] == 0, "R10 no beat at zero count", beats[0] + beats[1], 0);

        // Main scenario: ch1 single count 128 (size code ignored), ch0 burst 128 x 256
        cfg_write(1, 1'b0, 7, 128);
        cfg_write(0, 1'b1, 7, 256);
        check(cnt_of(0) == 256, "R2 write loads count", cnt_of(0), 256);
        pulse_req(2'b11);
        guard = 0;
        while (cnt_of(1) != 0 && guard < 2000) begin
            pulse_req(2'b10);
            repeat (4) @(negedge clk);
            guard++;
        end
        wait_idle();
        check(first_ch == 1, "R7 higher index served first", first_ch, 1);
        check(beats[1] == 128, "R3 single beats", beats[1], 128);
        check(beats[0] == 256, "R6 burst beats from one request", beats[0], 256);
        check(ch0_runs.size() == 2, "R5 burst run count", ch0_runs.size(), 2);
        foreach (ch0_runs[k]) check(ch0_runs[k] == 128, "R8 burst not preempted", ch0_runs[k], 128);
        check(done_cnt[0] == 1 && done_cnt[1] == 1, "R9 one done pulse each",
              done_cnt[0] + done_cnt[1], 2);

        // R5: final burst moves only the remainder (4, 4, 2)
        ch0_runs.delete();
        cfg_write(0, 1'b1, 2, 10);
        pulse_req(2'b01);
        wait_idle();
        check(ch0_runs.size() == 3, "R5 remainder run count", ch0_runs.size(), 3);
        if (ch0_runs.size() == 3)
            check(ch0_runs[0] == 4 && ch0_runs[1] == 4 && ch0_runs[2] == 2,
                  "R5 remainder run length", ch0_runs[2], 2);

        // R4: requests during a burst collapse to one pending beat
        cfg_write(1, 1'b0, 0, 5);
        cfg_write(0, 1'b1, 7, 100);
        pulse_req(2'b01);
        repeat (5) @(negedge clk);
        beats[1] = 0;
        pulse_req(2'b10);
        pulse_req(2'b10);
        pulse_req(2'b10);
        wait_idle();
        check(cnt_of(1) == 4, "R4 pending collapsed", cnt_of(1), 4);
        check(beats[1] == 1, "R4 one beat served", beats[1], 1);

        // R2: write to the running channel is dropped
        beats[0] = 0;
        cfg_write(0, 1'b1, 7, 200);
        pulse_req(2'b01);
        repeat (10) @(negedge clk);
        cfg_write(0, 1'b0, 0, 5);
        wait_idle();
        check(beats[0] == 200, "R2 write to owner ignored", beats[0], 200);
        cfg_write(1, 1'b0, 0, 3);
        check(cnt_of(1) == 3, "R2 idle write accepted", cnt_of(1), 3);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule